// File: doc/BRIEF.md
# Recording Overload Detector with Retriggerable Hold

This block watches the stream of recorded stereo samples leaving an analog-to-digital converter and raises a single overload flag whenever either channel comes close to full scale. A sample strobe marks each new left/right pair. The magnitude of each two's-complement sample is taken with the most negative code saturated, and it is compared against a programmable near-full-scale threshold. The default threshold is 0.875 of full scale, about 1.16 dB below the maximum swing.

Once triggered, the flag stays high for a fixed number of sample periods, counted in strobes and not in clock cycles. Each new violation restarts that hold window. A record-level meter or a gain-control loop can therefore read the flag at a slow rate and still see every short burst of clipping.

Top module: `adc_overload_hold`

## Requirements
- R1: While reset is asserted, and after it is released, the flag reads 0 until the first violating strobe.
- R2: A strobe whose left sample has magnitude strictly greater than THRESH (default 7340032 for 24-bit samples) drives the flag to 1 in the next clock cycle.
- R3: A strobe whose right sample has magnitude strictly greater than THRESH drives the flag to 1 in the next clock cycle, whatever the left sample is.
- R4: Magnitude is the absolute value of the signed sample. A sample of +THRESH or -THRESH does not trigger, and -(THRESH+1) does.
- R5: The most negative code (only the sign bit set) is treated as the largest positive magnitude, 2^(W-1)-1, and it triggers.
- R6: After the last violating strobe the flag stays 1 through HOLD (default 512) further non-violating strobes. It falls to 0 in the clock cycle after the HOLD-th of them.
- R7: A violating strobe during the hold window restarts the window, so that HOLD fresh non-violating strobes are needed before the flag falls.
- R8: Sample values present while the strobe is low have no effect. Without strobes the flag keeps its value, neither rising nor falling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe marking a new stereo sample pair |
| smp_l | input | W (24) | Left sample, signed two's complement |
| smp_r | input | W (24) | Right sample, signed two's complement |
| ovl_flag | output | 1 | Overload flag with retriggerable hold |

## Verification
The hardest situation to reach is the exact end of a restarted hold window. A second violation has to arrive partway through the first window. The bench must then count exactly HOLD non-violating strobes afterwards, with idle cycles between them, before the flag falls. The stimulus sets up this case directly and checks the flag one strobe before and one strobe after the expected fall. Idle gaps are filled with over-threshold values on both channels, so any leak of unstrobed data into the counter shows up as a mismatch. The code values at the threshold, one above it and the most negative code are each applied on their own, so that the strict comparison and the saturation are exercised separately.

// File: rtl/ovd_pkg.sv
package ovd_pkg;
  parameter int SAMPLE_W_DEF = 24;
  parameter int HOLD_DEF     = 512;
  parameter int THRESH_DEF   = 7340032;  // round(0.875 * 2^23)
  parameter int NUM_CH       = 2;
endpackage

// File: rtl/ovd_chan_cmp.sv
module ovd_chan_cmp #(
  parameter int W      = ovd_pkg::SAMPLE_W_DEF,
  parameter int THRESH = ovd_pkg::THRESH_DEF
) (
  input  logic [W-1:0] smp,
  output logic [W-2:0] mag,
  output logic         over
);
  localparam logic [W-2:0] TH_V    = THRESH[W-2:0];
  localparam logic [W-1:0] MOSTNEG = {1'b1, {(W-1){1'b0}}};

  // absolute value, most negative code saturated to the largest magnitude
  function automatic logic [W-2:0] sat_abs(input logic [W-1:0] v);
    logic [W-1:0] neg;
    neg = (~v) + 1'b1;
    if (!v[W-1])          return v[W-2:0];
    else if (v == MOSTNEG) return {(W-1){1'b1}};
    else                   return neg[W-2:0];
  endfunction

  assign mag  = sat_abs(smp);
  assign over = (mag > TH_V);
endmodule

// File: rtl/ovd_hold.sv
module ovd_hold #(
  parameter int HOLD = ovd_pkg::HOLD_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic viol,
  output logic flag
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);
  localparam logic [CW-1:0] ONE_V  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          flag_q;
  logic          last_tick;

  assign last_tick = strobe && !viol && (cnt_q == ONE_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (viol) begin
      cnt_q  <= HOLD_V;
      flag_q <= 1'b1;
    end else if (strobe && cnt_q != '0) begin
      cnt_q <= cnt_q - ONE_V;
      if (last_tick) flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;

  // R2: a violation raises the flag in the next cycle
  a_r2_viol_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> flag_q);
  // R7: a violation reloads the full hold window
  a_r7_retrig_reload: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> (cnt_q == HOLD_V));
  // R6: the window never exceeds HOLD
  a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= HOLD_V);
  // R6: the flag only falls right after a non-violating strobe
  a_r6_fall_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(strobe && !viol));
  // R8: no strobe, no change
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(flag_q) && $stable(cnt_q)));
endmodule

// File: rtl/adc_overload_hold.sv
module adc_overload_hold #(
  parameter int W      = ovd_pkg::SAMPLE_W_DEF,
  parameter int THRESH = ovd_pkg::THRESH_DEF,
  parameter int HOLD   = ovd_pkg::HOLD_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_vld,
  input  logic [W-1:0] smp_l,
  input  logic [W-1:0] smp_r,
  output logic         ovl_flag
);
  localparam int NCH = ovd_pkg::NUM_CH;

  logic [W-1:0]   smp_a  [NCH];
  logic [W-2:0]   mag_a  [NCH];
  logic [NCH-1:0] over_v;
  logic           viol;

  assign smp_a[0] = smp_l;
  assign smp_a[1] = smp_r;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    ovd_chan_cmp #(.W(W), .THRESH(THRESH)) cmp_i (
      .smp  (smp_a[ch]),
      .mag  (mag_a[ch]),
      .over (over_v[ch])
    );
  end

  assign viol = smp_vld && (|over_v);

  ovd_hold #(.HOLD(HOLD)) hold_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (smp_vld),
    .viol   (viol),
    .flag   (ovl_flag)
  );

  // R1: flag is low in the first cycle after reset
  a_r1_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !ovl_flag);
  // R8: flag cannot rise without a strobe
  a_r8_no_rise_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl_flag) |-> $past(smp_vld));
endmodule

// File: tb/adc_overload_hold_tb_top.sv
module adc_overload_hold_tb_top;
  localparam int W    = 24;
  localparam int TH   = 7340032;
  localparam int HOLD = 512;
  localparam longint MAXM = (64'sd1 <<< (W-1)) - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic smp_vld = 0;
  logic [W-1:0] smp_l = '0, smp_r = '0;
  logic ovl_flag;

  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  int ref_cnt = 0;
  bit ref_flag = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_overload_hold dut_i (.clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .smp_l(smp_l), .smp_r(smp_r), .ovl_flag(ovl_flag));

  function automatic longint mag_of(logic [W-1:0] v);
    longint s = longint'($signed(v));
    longint m = (s < 0) ? -s : s;
    return (m > MAXM) ? MAXM : m;
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin ref_cnt = 0; ref_flag = 0; end
    else if (smp_vld) begin
      if (mag_of(smp_l) > TH || mag_of(smp_r) > TH) begin
        ref_cnt = HOLD; ref_flag = 1;
      end else if (ref_cnt > 0) begin
        ref_cnt--;
        if (ref_cnt == 0) ref_flag = 0;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      n_tests++;
      if (ovl_flag !== ref_flag) begin
        n_fail++;
        $display("FAIL %s per-cycle: actual %0b expected %0b", cur_req, ovl_flag, ref_flag);
      end
    end
  end

  task automatic check(string req, bit act, bit exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // one strobe, then one idle cycle carrying over-threshold junk
  task automatic strobe(input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    smp_vld = 1; smp_l = l; smp_r = r;
    @(negedge clk);
    smp_vld = 0; smp_l = W'(TH + 5); smp_r = {1'b1, {(W-1){1'b0}}};
  endtask

  task automatic quiet(int n);
    for (int i = 0; i < n; i++) strobe(W'(1000), W'(-2000));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", ovl_flag, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", ovl_flag, 0);
    quiet(4);
    check("R1", ovl_flag, 0);

    cur_req = "R4";
    strobe(W'(TH), W'(-TH));
    check("R4", ovl_flag, 0);
    strobe(W'(-TH), W'(TH));
    check("R4", ovl_flag, 0);

    cur_req = "R2";
    strobe(W'(TH + 1), W'(0));
    check("R2", ovl_flag, 1);
    cur_req = "R6";
    quiet(HOLD - 1);
    check("R6", ovl_flag, 1);
    quiet(1);
    check("R6", ovl_flag, 0);

    cur_req = "R3";
    strobe(W'(5), W'(-(TH + 1)));
    check("R3", ovl_flag, 1);
    check("R4", ovl_flag, 1);
    quiet(HOLD);
    check("R3", ovl_flag, 0);

    cur_req = "R5";
    strobe({1'b1, {(W-1){1'b0}}}, W'(0));
    check("R5", ovl_flag, 1);

    cur_req = "R8";
    repeat (2000) @(negedge clk);
    check("R8", ovl_flag, 1);
    quiet(HOLD);
    check("R5", ovl_flag, 0);
    repeat (500) @(negedge clk);
    check("R8", ovl_flag, 0);

    cur_req = "R7";
    strobe(W'(-(TH + 100)), W'(TH + 100));
    quiet(300);
    strobe(W'(0), W'(MAXM));
    quiet(HOLD - 1);
    check("R7", ovl_flag, 1);
    quiet(1);
    check("R7", ovl_flag, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule